// File: doc/BRIEF.md
# Register Bitfield Execution Unit

This unit carries out one bitfield operation per cycle on a single data register. A field is described by a bit offset and a width. Either of the two can be an immediate carried in a 16-bit extension word, or it can be taken from the value of an auxiliary register. Offsets count from the most significant bit. A field that runs past the least significant bit continues at the most significant bit.

The supported operations are:
- test, change, clear and set, which work on the field in place;
- find-first-one;
- signed and unsigned extract;
- insert.

The unit returns the updated data register, a result for the second register named in the extension word, and the N and Z condition flags. All results are computed combinationally and captured in output registers, so they appear one clock after the request. Register file reads and writes, memory-operand forms and instruction fetch belong to the surrounding pipeline.

Top module: `bitfield_unit`

## Requirements
- R1: The extension word is decoded as follows. Bits 4:0 are the immediate width and bit 5 set takes the width from `width_reg`. Bits 10:6 are the immediate offset and bit 11 set takes the offset from `offset_reg`. Bits 14:12 are copied to `res_idx`, and bit 15 is ignored.
- R2: A register width uses only its value modulo 32. A width of 0, whether immediate or from a register, means 32.
- R3: A register offset uses only its value modulo 32.
- R4: Offset 0 names bit 31. Field bit k lies at register bit 31-((offset+k) mod 32), so a field wraps from bit 0 to bit 31.
- R5: Change (op 0xA) inverts the field bits in `dst_val`, clear (0xC) zeroes them and set (0xE) makes them one. All other bits keep their value, `dst_we` is raised and `res_we` stays low.
- R6: Test (op 0x8) updates only the flags. Both write enables stay low and `dst_val` equals `src_reg`.
- R7: Insert (op 0xF) writes the low width bits of `aux_reg` into the field, with the MSB of that slice going to field bit 0. The other bits of `src_reg` are unchanged and `dst_we` is raised.
- R8: Unsigned extract (op 0x9) returns the field zero-extended in `res_val`, and signed extract (op 0xB) returns it sign-extended. Both raise `res_we`.
- R9: Find-first-one (op 0xD) returns, with `res_we`, the offset plus the index of the first set field bit. If the field is all zero it returns the offset plus the width.
- R10: For every operation except insert, N is field bit 0 and Z is set when the field is all zero. V and C are always 0.
- R11: For insert, N and Z describe the inserted slice of `aux_reg` rather than the old field contents.
- R12: A select code outside the eight listed above raises no write enable and leaves N and Z unchanged.
- R13: Results appear one clock after `in_valid`. In a cycle without `in_valid` both enables are low and the flags hold. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 4 | Operation select |
| ext_word | input | 16 | Extension word |
| src_reg | input | 32 | Data register holding the field |
| aux_reg | input | 32 | Second register value (insert source) |
| width_reg | input | 32 | Register supplying a variable width |
| offset_reg | input | 32 | Register supplying a variable offset |
| out_valid | output | 1 | Result registers hold a new result |
| dst_we | output | 1 | Write `dst_val` back to the data register |
| dst_val | output | 32 | Updated data register |
| res_we | output | 1 | Write `res_val` to the second register |
| res_idx | output | 3 | Index of the second register |
| res_val | output | 32 | Extract or find-first-one result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag, always 0 |
| flag_c | output | 1 | Carry flag, always 0 |

## Verification
All 1024 combinations of immediate offset and width are applied for every operation, with three data patterns:
- A mixed value exposes misplaced or mis-ordered field bits. Offsets past 32 minus width separate a correct wrap from a plain shift.
- All-zero data isolates the empty-field cases of find-first-one and Z.
- All-ones data isolates the sign-extension and N cases.

A pseudo-random sweep then selects register widths and offsets whose upper bits are set, including width values that are multiples of 32, to separate modulo handling from full-value use. Finally, undefined select codes and idle cycles check that the flags are held.

// File: rtl/bf_pkg.sv
package bf_pkg;

    typedef enum logic [3:0] {
        BF_TST  = 4'h8,
        BF_EXTU = 4'h9,
        BF_CHG  = 4'hA,
        BF_EXTS = 4'hB,
        BF_CLR  = 4'hC,
        BF_FFO  = 4'hD,
        BF_SET  = 4'hE,
        BF_INS  = 4'hF
    } bf_op_e;

    function automatic logic bf_op_known(input logic [3:0] code);
        return code[3];
    endfunction

endpackage

// File: rtl/bf_field_decode.sv
module bf_field_decode #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5,
    parameter int EXT_W  = 16
) (
    input  logic [EXT_W-1:0]  ext_word,
    input  logic [DATA_W-1:0] width_reg,
    input  logic [DATA_W-1:0] offset_reg,
    output logic [IDX_W:0]    fld_width,
    output logic [IDX_W-1:0]  fld_offset,
    output logic [2:0]        sel_idx
);
    localparam int WSEL_BIT = IDX_W;
    localparam int OFS_LO   = IDX_W + 1;
    localparam int OSEL_BIT = 2 * IDX_W + 1;
    localparam int IDX_LO   = 2 * IDX_W + 2;

    logic [IDX_W-1:0] width_raw;
    logic             unused_bits;

    always_comb begin
        width_raw  = ext_word[WSEL_BIT] ? width_reg[IDX_W-1:0] : ext_word[IDX_W-1:0];
        fld_width  = (width_raw == '0) ? (IDX_W+1)'(DATA_W) : {1'b0, width_raw};
        fld_offset = ext_word[OSEL_BIT] ? offset_reg[IDX_W-1:0]
                                        : ext_word[OFS_LO +: IDX_W];
        sel_idx    = ext_word[IDX_LO +: 3];
    end

    assign unused_bits = ^{width_reg[DATA_W-1:IDX_W], offset_reg[DATA_W-1:IDX_W],
                           ext_word[EXT_W-1:IDX_LO+3]};
endmodule

// File: rtl/bf_rotate.sv
module bf_rotate #(
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 5,
    parameter bit ROT_LEFT = 1'b1
) (
    input  logic [DATA_W-1:0] data_in,
    input  logic [IDX_W-1:0]  amount,
    output logic [DATA_W-1:0] data_out
);
    logic [2*DATA_W-1:0] doubled;

    generate
        if (ROT_LEFT) begin : g_left
            always_comb begin
                doubled  = {data_in, data_in} << amount;
                data_out = doubled[2*DATA_W-1:DATA_W];
            end
        end else begin : g_right
            always_comb begin
                doubled  = {data_in, data_in} >> amount;
                data_out = doubled[DATA_W-1:0];
            end
        end
    endgenerate
endmodule

// File: rtl/bf_lead_zero.sv
module bf_lead_zero #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input  logic [DATA_W-1:0] vec,
    output logic [IDX_W:0]    count,
    output logic              all_zero
);
    always_comb begin
        count = (IDX_W+1)'(DATA_W);
        for (int i = 0; i < DATA_W; i++) begin
            if (vec[i]) begin
                count = (IDX_W+1)'(DATA_W - 1 - i);
            end
        end
        all_zero = (vec == '0);
    end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit #(
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DATA_W),
    localparam int EXT_W = 2 * IDX_W + 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op_sel,
    input  logic [EXT_W-1:0]  ext_word,
    input  logic [DATA_W-1:0] src_reg,
    input  logic [DATA_W-1:0] aux_reg,
    input  logic [DATA_W-1:0] width_reg,
    input  logic [DATA_W-1:0] offset_reg,
    output logic              out_valid,
    output logic              dst_we,
    output logic [DATA_W-1:0] dst_val,
    output logic              res_we,
    output logic [2:0]        res_idx,
    output logic [DATA_W-1:0] res_val,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_c
);
    import bf_pkg::*;

    localparam logic [DATA_W-1:0] ONES = '1;

    typedef struct packed {
        logic              valid;
        logic              dst_we;
        logic [DATA_W-1:0] dst;
        logic              res_we;
        logic [2:0]        idx;
        logic [DATA_W-1:0] res;
        logic              n;
        logic              z;
    } bf_state_t;

    bf_state_t st_d, st_q;

    logic [IDX_W:0]    width;
    logic [IDX_W-1:0]  offset;
    logic [2:0]        sel_idx;
    logic [IDX_W-1:0]  shamt;
    logic [DATA_W-1:0] top_mask, fld_mask, src_rot, field_top;
    logic [DATA_W-1:0] ins_top, ins_place, ext_u, ext_s;
    logic [IDX_W:0]    lead_cnt;
    logic              field_zero;
    logic [IDX_W+1:0]  ffo_pos;

    bf_field_decode #(.DATA_W(DATA_W), .IDX_W(IDX_W), .EXT_W(EXT_W)) u_decode (
        .ext_word  (ext_word),
        .width_reg (width_reg),
        .offset_reg(offset_reg),
        .fld_width (width),
        .fld_offset(offset),
        .sel_idx   (sel_idx)
    );

    always_comb begin
        shamt    = IDX_W'((IDX_W+1)'(DATA_W) - width);
        top_mask = ONES << shamt;
        ins_top  = aux_reg << shamt;
    end

    bf_rotate #(.DATA_W(DATA_W), .IDX_W(IDX_W), .ROT_LEFT(1'b1)) u_src_rot (
        .data_in (src_reg),
        .amount  (offset),
        .data_out(src_rot)
    );

    bf_rotate #(.DATA_W(DATA_W), .IDX_W(IDX_W), .ROT_LEFT(1'b0)) u_mask_rot (
        .data_in (top_mask),
        .amount  (offset),
        .data_out(fld_mask)
    );

    bf_rotate #(.DATA_W(DATA_W), .IDX_W(IDX_W), .ROT_LEFT(1'b0)) u_ins_rot (
        .data_in (ins_top),
        .amount  (offset),
        .data_out(ins_place)
    );

    assign field_top = src_rot & top_mask;

    bf_lead_zero #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_lzc (
        .vec     (field_top),
        .count   (lead_cnt),
        .all_zero(field_zero)
    );

    always_comb begin
        ext_u   = field_top >> shamt;
        ext_s   = DATA_W'($signed(field_top) >>> shamt);
        ffo_pos = (IDX_W+2)'(offset) + (IDX_W+2)'(field_zero ? width : lead_cnt);
    end

    always_comb begin
        st_d        = st_q;
        st_d.valid  = in_valid;
        st_d.dst_we = 1'b0;
        st_d.res_we = 1'b0;
        if (in_valid) begin
            st_d.idx = sel_idx;
            st_d.dst = src_reg;
            st_d.res = '0;
            if (bf_op_known(op_sel)) begin
                st_d.n = field_top[DATA_W-1];
                st_d.z = field_zero;
            end
            case (op_sel)
                BF_CHG: begin
                    st_d.dst    = src_reg ^ fld_mask;
                    st_d.dst_we = 1'b1;
                end
                BF_CLR: begin
                    st_d.dst    = src_reg & ~fld_mask;
                    st_d.dst_we = 1'b1;
                end
                BF_SET: begin
                    st_d.dst    = src_reg | fld_mask;
                    st_d.dst_we = 1'b1;
                end
                BF_INS: begin
                    st_d.dst    = (src_reg & ~fld_mask) | ins_place;
                    st_d.dst_we = 1'b1;
                    st_d.n      = ins_top[DATA_W-1];
                    st_d.z      = (ins_top == '0);
                end
                BF_EXTU: begin
                    st_d.res    = ext_u;
                    st_d.res_we = 1'b1;
                end
                BF_EXTS: begin
                    st_d.res    = ext_s;
                    st_d.res_we = 1'b1;
                end
                BF_FFO: begin
                    st_d.res    = DATA_W'(ffo_pos);
                    st_d.res_we = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign dst_we    = st_q.dst_we;
    assign dst_val   = st_q.dst;
    assign res_we    = st_q.res_we;
    assign res_idx   = st_q.idx;
    assign res_val   = st_q.res;
    assign flag_n    = st_q.n;
    assign flag_z    = st_q.z;
    assign flag_v    = 1'b0;
    assign flag_c    = 1'b0;
endmodule

// File: rtl/bitfield_unit_chk.sv
module bitfield_unit_chk #(
    parameter int DATA_W = 32,
    parameter int EXT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [3:0]        op_sel,
    input logic [EXT_W-1:0]  ext_word,
    input logic [DATA_W-1:0] src_reg,
    input logic              out_valid,
    input logic              dst_we,
    input logic [DATA_W-1:0] dst_val,
    input logic              res_we,
    input logic [DATA_W-1:0] res_val,
    input logic              flag_n,
    input logic              flag_z
);
    logic op_defined;
    assign op_defined = (op_sel >= 4'h8);

    assert_write_needs_valid_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_we || res_we) |-> out_valid);

    assert_idle_holds_flags_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!dst_we && !res_we && $stable(flag_n) && $stable(flag_z)));

    assert_single_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dst_we, res_we}));

    assert_test_keeps_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 4'h8) |=> (!dst_we && !res_we && dst_val == $past(src_reg)));

    assert_ffo_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 4'hD) |=> (res_we && res_val < DATA_W'(2 * DATA_W)));

    assert_zero_not_negative_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flag_z |-> !flag_n);

    assert_bad_op_holds_flags_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op_defined) |=> (!dst_we && !res_we && $stable(flag_n) && $stable(flag_z)));

    logic unused_chk;
    assign unused_chk = ^ext_word;
endmodule

bind bitfield_unit bitfield_unit_chk #(.DATA_W(DATA_W), .EXT_W(EXT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .op_sel   (op_sel),
    .ext_word (ext_word),
    .src_reg  (src_reg),
    .out_valid(out_valid),
    .dst_we   (dst_we),
    .dst_val  (dst_val),
    .res_we   (res_we),
    .res_val  (res_val),
    .flag_n   (flag_n),
    .flag_z   (flag_z)
);

// File: tb/bitfield_unit_test.sv
module bitfield_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op_sel = 4'h0;
    logic [15:0] ext_word = '0;
    logic [31:0] src_reg = '0, aux_reg = '0, width_reg = '0, offset_reg = '0;
    logic        out_valid, dst_we, res_we, flag_n, flag_z, flag_v, flag_c;
    logic [31:0] dst_val, res_val;
    logic [2:0]  res_idx;

    int checks = 0;
    int errors = 0;
    logic exp_n = 1'b0, exp_z = 1'b0;
    logic [31:0] rng = 32'h1234_5678;

    always #5 clk = ~clk;

    bitfield_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .ext_word(ext_word), .src_reg(src_reg), .aux_reg(aux_reg),
        .width_reg(width_reg), .offset_reg(offset_reg), .out_valid(out_valid),
        .dst_we(dst_we), .dst_val(dst_val), .res_we(res_we), .res_idx(res_idx),
        .res_val(res_val), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v),
        .flag_c(flag_c)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic string op_tag(input logic [3:0] op);
        case (op)
            4'h8: return "R6";
            4'hA, 4'hC, 4'hE: return "R5";
            4'hF: return "R7";
            4'h9, 4'hB: return "R8";
            4'hD: return "R9";
            default: return "R12";
        endcase
    endfunction

    function automatic logic [31:0] next_rng(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        return y ^ (y << 5);
    endfunction

    // Apply one request at a falling edge and check one cycle later.
    task automatic run_op(input logic [3:0] op, input logic [15:0] ext,
                          input logic [31:0] s, input logic [31:0] a,
                          input logic [31:0] wr, input logic [31:0] orr,
                          input string pre);
        int w, o;
        logic [31:0] fv, u, e_dst, e_res;
        logic e_dw, e_rw, known;
        int first;
        string tag;
        w = ext[5] ? int'(wr % 32) : int'(ext[4:0]);
        if (w == 0) w = 32;
        o = ext[11] ? int'(orr % 32) : int'(ext[10:6]);
        fv = '0;
        for (int k = 0; k < w; k++) fv[k] = s[31 - ((o + k) % 32)];
        u = '0;
        first = w;
        for (int k = w - 1; k >= 0; k--) if (fv[k]) first = k;
        for (int k = 0; k < w; k++) u = (u << 1) | {31'b0, fv[k]};
        e_dst = s;
        e_res = '0;
        e_dw = 1'b0;
        e_rw = 1'b0;
        known = op[3];
        case (op)
            4'hA: begin e_dw = 1; for (int k = 0; k < w; k++) e_dst[31-((o+k)%32)] = ~fv[k]; end
            4'hC: begin e_dw = 1; for (int k = 0; k < w; k++) e_dst[31-((o+k)%32)] = 1'b0; end
            4'hE: begin e_dw = 1; for (int k = 0; k < w; k++) e_dst[31-((o+k)%32)] = 1'b1; end
            4'hF: begin e_dw = 1; for (int k = 0; k < w; k++) e_dst[31-((o+k)%32)] = a[w-1-k]; end
            4'h9: begin e_rw = 1; e_res = u; end
            4'hB: begin
                e_rw = 1; e_res = u;
                if (fv[0]) for (int b = w; b < 32; b++) e_res[b] = 1'b1;
            end
            4'hD: begin e_rw = 1; e_res = 32'(o + first); end
            default: ;
        endcase
        if (known) begin
            if (op == 4'hF) begin
                exp_n = a[w-1];
                exp_z = 1'b1;
                for (int k = 0; k < w; k++) if (a[k]) exp_z = 1'b0;
            end else begin
                exp_n = fv[0];
                exp_z = (u == 0);
            end
        end
        in_valid   = 1'b1;
        op_sel     = op;
        ext_word   = ext;
        src_reg    = s;
        aux_reg    = a;
        width_reg  = wr;
        offset_reg = orr;
        @(negedge clk);
        in_valid = 1'b0;
        tag = {pre, " ", op_tag(op)};
        chk({tag, " R13"}, "out_valid", {31'b0, out_valid}, 32'd1);
        chk(tag, "dst_we", {31'b0, dst_we}, {31'b0, e_dw});
        chk(tag, "res_we", {31'b0, res_we}, {31'b0, e_rw});
        if (known) chk(tag, "dst_val", dst_val, e_dst);
        if (e_rw) chk(tag, "res_val", res_val, e_res);
        chk({pre, " R1"}, "res_idx", {29'b0, res_idx}, {29'b0, ext[14:12]});
        chk({tag, (op == 4'hF) ? " R11" : " R10"}, "flags N Z V C",
            {28'b0, flag_n, flag_z, flag_v, flag_c}, {28'b0, exp_n, exp_z, 2'b00});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R13 watchdog expired actual %0d expected %0d", checks, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0] ops [8];
        ops = '{4'h8, 4'hA, 4'hC, 4'hD, 4'hE, 4'h9, 4'hB, 4'hF};
        repeat (3) @(negedge clk);
        // R13: reset state
        chk("R13", "reset outputs",
            {22'b0, out_valid, dst_we, res_we, res_idx, flag_n, flag_z, flag_v, flag_c},
            32'd0);
        chk("R13", "reset dst_val", dst_val, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R4: immediate width and offset sweep, wrap cases included.
        for (int p = 0; p < 3; p++) begin
            for (int oi = 0; oi < 8; oi++) begin
                for (int o = 0; o < 32; o++) begin
                    for (int w = 1; w <= 32; w++) begin
                        logic [31:0] s, a;
                        logic [15:0] ext;
                        s = (p == 0) ? (32'(o) * 32'h9E37_79B1) ^ (32'(w) * 32'h7F4A_7C15) ^ 32'hA5C3_0F96
                          : (p == 1) ? 32'h0 : 32'hFFFF_FFFF;
                        a = {s[15:0], s[31:16]} ^ 32'h3C5A_F00F;
                        ext = {1'b1, 3'(o + w), 1'b0, 5'(o), 1'b0, 5'(w % 32)};
                        run_op(ops[oi], ext, s, a, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1 R4");
                    end
                end
            end
        end

        // R2 R3: register width and offset, upper bits set.
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] s, a, wr, orr;
            logic [15:0] ext;
            rng = next_rng(rng); s = rng;
            rng = next_rng(rng); a = rng;
            rng = next_rng(rng); wr = (i % 5 == 0) ? (rng & 32'hFFFF_FFE0) : rng;
            rng = next_rng(rng); orr = rng;
            rng = next_rng(rng);
            ext = rng[15:0];
            ext[5]  = ext[5] | (i % 2 == 0);
            ext[11] = ext[11] | (i % 3 == 0);
            run_op(ops[i % 8], ext, s, a, wr, orr, "R2/R3");
        end

        // R12: undefined select codes leave writes off and flags held.
        for (int c = 0; c < 8; c++) begin
            run_op(4'h9, {1'b0, 3'd2, 1'b0, 5'd0, 1'b0, 5'd1}, 32'h8000_0000, 0, 0, 0, "R12 setup");
            run_op(4'(c), {1'b0, 3'd5, 1'b0, 5'd3, 1'b0, 5'd4}, 32'h0, 32'h0, 0, 0, "R12");
        end

        // R13: idle cycle keeps enables low and flags held.
        run_op(4'h8, {1'b0, 3'd1, 1'b0, 5'd0, 1'b0, 5'd8}, 32'hFF00_0000, 0, 0, 0, "R13 setup");
        @(negedge clk);
        chk("R13", "idle enables", {30'b0, dst_we, res_we}, 32'd0);
        chk("R13", "idle flags N Z", {30'b0, flag_n, flag_z}, {30'b0, exp_n, exp_z});

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule